// File: doc/BRIEF.md
# Two-Point Gain and Offset Calibrator

This block sits after a column converter that digitizes each sample in one of three gain modes (high, medium, low) and puts medium-gain and low-gain results back onto the high-gain code scale. It has two uses. In calibration use, two known input levels have each been converted in all three modes. Those six codes are fed in, each tagged with its gain mode and point number. The block then derives a gain ratio and an offset for the medium mode and for the low mode, and keeps them.

In streaming use, every incoming sample carries a gain tag. Medium and low samples are scaled by their ratio, rounded, shifted by their offset and clamped to the output range. High-gain samples leave unchanged.

Ratios are unsigned fixed point with `FRAC` fractional bits, so unity is 4096 by default. A restoring divider produces them over many cycles, and a busy flag covers that time. Calibration points whose difference is not positive are rejected: the block raises an error flag and falls back to unity ratios and zero offsets.

Top module: `gcal_corrector`

## Requirements
- R1: After reset, out_valid, busy and cal_err are 0, ratios are unity (4096) and offsets are 0, so a medium-gain or low-gain sample is output unchanged.
- R2: Gain tag encoding: 0 = high, 1 = medium, 2 = low, 3 = reserved. Tags 0 and 3 in streaming use pass the code through unchanged.
- R3: With cal_mode=1, an accepted sample with tag 0..2 is stored in slot (tag, cal_point) and produces no output. Once all six slots have been filled since the last calibration, busy rises in the following cycle.
- R4: Let dH, dM and dL be the point-1 code minus the point-0 code for each mode. The medium ratio is floor(dH*4096/dM) and the low ratio is floor(dH*4096/dL), each saturated to 65535.
- R5: Each offset is ((ratio*X1 + 2048) >> 12) - H1, where X1 is that mode's point-1 code and H1 is the high-gain point-1 code.
- R6: A medium or low sample s yields ((ratio*s + 2048) >> 12) - offset, using that mode's terms, clamped to 0..8191 on a 13-bit output.
- R7: If dH, dM or dL is zero or negative, busy is high for exactly one cycle, cal_err becomes 1, and the ratios return to unity with zero offsets.
- R8: While busy is 1, in_ready is 0. Busy stays high for no more than 64 cycles.
- R9: A sample accepted at a clock edge appears with out_valid at the next edge, provided the output is free. While out_valid=1 and out_ready=0, out_valid and out_code hold.
- R10: A calibration that completes without error clears cal_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_code | input | 13 | Converter code |
| in_gain | input | 2 | Gain tag of the code |
| cal_mode | input | 1 | Sample is a calibration point |
| cal_point | input | 1 | Calibration point number (0 lower, 1 upper) |
| out_valid | output | 1 | Corrected sample valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_code | output | 13 | Corrected sample |
| busy | output | 1 | Coefficient computation in progress |
| cal_err | output | 1 | Last calibration rejected |

## Verification
Samples go through the block in three coefficient states: reset unity, an ideal calibration whose ratios are exact powers of two, and a non-ideal one whose ratio has a remainder and whose offset is non-zero. This separates a rounding or offset-sign error from a plain scaling error. A calibration with only a one-code medium difference drives the ratio into saturation. Samples at the top and bottom of the range reach both clamp limits. A calibration with equal medium points exercises the rejection path and its fallback to unity terms, and the next good calibration is checked to clear the flag. A stalled output is held for several cycles to confirm that the handshake keeps it.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
   typedef enum logic [1:0] {
      GAIN_HI  = 2'd0,
      GAIN_MD  = 2'd1,
      GAIN_LO  = 2'd2,
      GAIN_RSV = 2'd3
   } gain_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIVM = 2'd1,
      ST_DIVL = 2'd2,
      ST_OFFS = 2'd3
   } cal_st_e;
endpackage

// File: rtl/gcal_divider.sv
module gcal_divider #(
   parameter int NUM_W = 25,
   parameter int DEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quot
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W:0]   rem;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] num_q;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [DEN_W:0]   trial;

   assign trial = {rem[DEN_W-1:0], quot[NUM_W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         quot  <= '0;
         den_q <= '0;
         num_q <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem   <= '0;
            quot  <= num;
            num_q <= num;
            den_q <= den;
            cnt   <= CNT_W'(NUM_W);
            run   <= 1'b1;
         end else if (run) begin
            if (trial >= {1'b0, den_q}) begin
               rem  <= trial - {1'b0, den_q};
               quot <= {quot[NUM_W-2:0], 1'b1};
            end else begin
               rem  <= trial;
               quot <= {quot[NUM_W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   logic [NUM_W+DEN_W:0] recon;
   assign recon = (NUM_W+DEN_W+1)'(quot) * (NUM_W+DEN_W+1)'(den_q)
                + (NUM_W+DEN_W+1)'(rem);

   a_r4_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (recon == (NUM_W+DEN_W+1)'(num_q)) && (rem < {1'b0, den_q}));
endmodule

// File: rtl/gcal_coef.sv
module gcal_coef
   import gcal_pkg::*;
#(
   parameter int CODE_W = 13,
   parameter int FRAC   = 12,
   parameter int INT_W  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cap_en,
   input  logic [CODE_W-1:0]               cap_code,
   input  logic [1:0]                      cap_gain,
   input  logic                            cap_pt,
   output logic [INT_W+FRAC-1:0]           ratio_md,
   output logic [INT_W+FRAC-1:0]           ratio_lo,
   output logic signed [INT_W+CODE_W+1:0]  off_md,
   output logic signed [INT_W+CODE_W+1:0]  off_lo,
   output logic                            busy,
   output logic                            cal_err
);
   localparam int RAT_W = INT_W + FRAC;
   localparam int NUM_W = CODE_W + FRAC;
   localparam int SC_W  = RAT_W + CODE_W;
   localparam int OFF_W = INT_W + CODE_W + 2;
   localparam logic [RAT_W-1:0] ONE = RAT_W'(1) << FRAC;
   localparam logic [SC_W:0]    HALF = (SC_W+1)'(1) << (FRAC - 1);

   typedef logic [SC_W:0]              sc_t;
   typedef logic signed [OFF_W-1:0]    off_t;
   typedef logic signed [CODE_W:0]     dif_t;

   logic [CODE_W-1:0] tbl [3][2];
   logic [5:0]        mask;
   cal_st_e           st;
   logic              full, bad, div_start, div_done;
   dif_t              d_h, d_m, d_l;
   logic [NUM_W-1:0]  div_num, div_q;
   logic [CODE_W-1:0] div_den;
   logic [RAT_W-1:0]  q_sat;
   sc_t               p_md, p_lo;

   assign full = &mask;
   assign busy = full || (st != ST_IDLE);
   assign d_h  = dif_t'({1'b0, tbl[0][1]}) - dif_t'({1'b0, tbl[0][0]});
   assign d_m  = dif_t'({1'b0, tbl[1][1]}) - dif_t'({1'b0, tbl[1][0]});
   assign d_l  = dif_t'({1'b0, tbl[2][1]}) - dif_t'({1'b0, tbl[2][0]});
   assign bad  = (d_h <= 0) || (d_m <= 0) || (d_l <= 0);

   assign div_start = (st == ST_IDLE && full && !bad) || (st == ST_DIVM && div_done);
   assign div_num   = {d_h[CODE_W-1:0], {FRAC{1'b0}}};
   assign div_den   = (st == ST_IDLE) ? d_m[CODE_W-1:0] : d_l[CODE_W-1:0];
   assign q_sat     = (|(div_q >> RAT_W)) ? '1 : div_q[RAT_W-1:0];

   assign p_md = sc_t'(ratio_md) * sc_t'(tbl[1][1]) + HALF;
   assign p_lo = sc_t'(ratio_lo) * sc_t'(tbl[2][1]) + HALF;

   gcal_divider #(.NUM_W(NUM_W), .DEN_W(CODE_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_start),
      .num   (div_num),
      .den   (div_den),
      .done  (div_done),
      .quot  (div_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < 3; g++) begin
            tbl[g][0] <= '0;
            tbl[g][1] <= '0;
         end
         mask     <= '0;
         st       <= ST_IDLE;
         ratio_md <= ONE;
         ratio_lo <= ONE;
         off_md   <= '0;
         off_lo   <= '0;
         cal_err  <= 1'b0;
      end else begin
         if (cap_en && cap_gain != GAIN_RSV) begin
            tbl[cap_gain][cap_pt]     <= cap_code;
            mask[{cap_gain, cap_pt}]  <= 1'b1;
         end
         case (st)
            ST_IDLE: if (full) begin
               mask <= '0;
               if (bad) begin
                  cal_err  <= 1'b1;
                  ratio_md <= ONE;
                  ratio_lo <= ONE;
                  off_md   <= '0;
                  off_lo   <= '0;
               end else begin
                  st <= ST_DIVM;
               end
            end
            ST_DIVM: if (div_done) begin
               ratio_md <= q_sat;
               st       <= ST_DIVL;
            end
            ST_DIVL: if (div_done) begin
               ratio_lo <= q_sat;
               st       <= ST_OFFS;
            end
            default: begin
               off_md  <= off_t'({1'b0, p_md[SC_W:FRAC]}) - off_t'({1'b0, tbl[0][1]});
               off_lo  <= off_t'({1'b0, p_lo[SC_W:FRAC]}) - off_t'({1'b0, tbl[0][1]});
               cal_err <= 1'b0;
               st      <= ST_IDLE;
            end
         endcase
      end
   end

   a_r7_err_unity: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_err) |-> (ratio_md == ONE) && (ratio_lo == ONE) && (off_md == 0) && (off_lo == 0));
   a_r8_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |-> !cap_en);
endmodule

// File: rtl/gcal_datapath.sv
module gcal_datapath
   import gcal_pkg::*;
#(
   parameter int CODE_W = 13,
   parameter int OUT_W  = 13,
   parameter int FRAC   = 12,
   parameter int INT_W  = 4,
   parameter bit ROUND  = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            acc,
   input  logic [CODE_W-1:0]               code,
   input  logic [1:0]                      gain,
   input  logic [INT_W+FRAC-1:0]           ratio_md,
   input  logic [INT_W+FRAC-1:0]           ratio_lo,
   input  logic signed [INT_W+CODE_W+1:0]  off_md,
   input  logic signed [INT_W+CODE_W+1:0]  off_lo,
   output logic                            take,
   output logic                            out_valid,
   input  logic                            out_ready,
   output logic [OUT_W-1:0]                out_code
);
   localparam int RAT_W = INT_W + FRAC;
   localparam int SC_W  = RAT_W + CODE_W;
   localparam int OFF_W = INT_W + CODE_W + 2;
   localparam int VAL_W = OFF_W + 1;
   localparam logic [RAT_W-1:0] ONE = RAT_W'(1) << FRAC;

   typedef logic [SC_W:0]           sc_t;
   typedef logic signed [VAL_W-1:0] val_t;

   localparam val_t MAXO = val_t'((VAL_W)'(1) << OUT_W) - val_t'(1);

   sc_t                    half;
   logic                   s1_v, s2_take, s1_load;
   sc_t                    s1_prod, rnd;
   logic signed [OFF_W-1:0] s1_off, off_sel;
   logic [RAT_W-1:0]       rat_sel;
   val_t                   val;
   logic [OUT_W-1:0]       clamped;

   generate
      if (ROUND) begin : g_round
         assign half = sc_t'(1) << (FRAC - 1);
      end else begin : g_trunc
         assign half = '0;
      end
   endgenerate

   assign s2_take = !out_valid || out_ready;
   assign s1_load = !s1_v || s2_take;
   assign take    = s1_load;

   always_comb begin
      case (gain)
         GAIN_MD: begin rat_sel = ratio_md; off_sel = off_md; end
         GAIN_LO: begin rat_sel = ratio_lo; off_sel = off_lo; end
         default: begin rat_sel = ONE;      off_sel = '0;     end
      endcase
   end

   assign rnd = s1_prod + half;
   assign val = val_t'({2'b00, rnd[SC_W:FRAC]}) - val_t'(s1_off);

   always_comb begin
      if (val < 0)         clamped = '0;
      else if (val > MAXO) clamped = '1;
      else                 clamped = val[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_prod   <= '0;
         s1_off    <= '0;
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         if (s1_load) begin
            s1_v    <= acc;
            s1_prod <= sc_t'(rat_sel) * sc_t'(code);
            s1_off  <= off_sel;
         end
         if (s2_take) begin
            out_valid <= s1_v;
            out_code  <= clamped;
         end
      end
   end

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_code));
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> s1_v);
   a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
      s1_v && s2_take |=> out_valid);
endmodule

// File: rtl/gcal_corrector.sv
module gcal_corrector
   import gcal_pkg::*;
#(
   parameter int CODE_W = 13,
   parameter int OUT_W  = 13,
   parameter int FRAC   = 12,
   parameter int INT_W  = 4,
   parameter bit ROUND  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CODE_W-1:0] in_code,
   input  logic [1:0]        in_gain,
   input  logic              cal_mode,
   input  logic              cal_point,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [OUT_W-1:0]  out_code,
   output logic              busy,
   output logic              cal_err
);
   localparam int RAT_W = INT_W + FRAC;
   localparam int OFF_W = INT_W + CODE_W + 2;

   generate
      if (FRAC < 2 || INT_W < 1) begin : g_bad_fmt
         $error("gcal_corrector: FRAC must be >= 2 and INT_W >= 1");
      end
      if (CODE_W < 2 || OUT_W < 2) begin : g_bad_w
         $error("gcal_corrector: code widths must be >= 2");
      end
   endgenerate

   logic                    dp_take, acc, cap_en;
   logic [RAT_W-1:0]        ratio_md, ratio_lo;
   logic signed [OFF_W-1:0] off_md, off_lo;

   assign in_ready = dp_take && !busy;
   assign acc      = in_valid && in_ready && !cal_mode;
   assign cap_en   = in_valid && in_ready && cal_mode;

   gcal_coef #(.CODE_W(CODE_W), .FRAC(FRAC), .INT_W(INT_W)) u_coef (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_code (in_code),
      .cap_gain (in_gain),
      .cap_pt   (cal_point),
      .ratio_md (ratio_md),
      .ratio_lo (ratio_lo),
      .off_md   (off_md),
      .off_lo   (off_lo),
      .busy     (busy),
      .cal_err  (cal_err)
   );

   gcal_datapath #(.CODE_W(CODE_W), .OUT_W(OUT_W), .FRAC(FRAC), .INT_W(INT_W),
                   .ROUND(ROUND)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .code      (in_code),
      .gain      (in_gain),
      .ratio_md  (ratio_md),
      .ratio_lo  (ratio_lo),
      .off_md    (off_md),
      .off_lo    (off_lo),
      .take      (dp_take),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_code  (out_code)
   );

   a_r3_cal_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en && !u_dp.s1_v |=> !u_dp.s1_v);
endmodule

// File: tb/tb_gcal_corrector.sv
module tb_gcal_corrector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [12:0] in_code = '0;
   logic [1:0]  in_gain = '0;
   logic        cal_mode = 1'b0;
   logic        cal_point = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [12:0] out_code;
   logic        busy;
   logic        cal_err;

   int n_tests = 0;
   int n_fail  = 0;
   longint r_md = 4096, r_lo = 4096, o_md = 0, o_lo = 0;

   always #10 clk = ~clk;

   gcal_corrector dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_code(in_code), .in_gain(in_gain), .cal_mode(cal_mode),
      .cal_point(cal_point), .out_valid(out_valid), .out_ready(out_ready),
      .out_code(out_code), .busy(busy), .cal_err(cal_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint f_ratio(longint h0, longint h1, longint x0, longint x1);
      longint q;
      q = ((h1 - h0) * 4096) / (x1 - x0);
      return (q > 65535) ? 65535 : q;
   endfunction

   function automatic longint f_corr(longint r, longint o, longint s);
      longint v;
      v = ((r * s + 2048) >>> 12) - o;
      if (v < 0) v = 0;
      if (v > 8191) v = 8191;
      return v;
   endfunction

   function automatic longint f_exp(longint s, int g);
      if (g == 1) return f_corr(r_md, o_md, s);
      if (g == 2) return f_corr(r_lo, o_lo, s);
      return s;
   endfunction

   task automatic drive(input int code, input int g, input bit cal, input bit pt);
      @(negedge clk);
      in_code = 13'(code); in_gain = 2'(g); cal_mode = cal; cal_point = pt;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0; cal_mode = 1'b0;
   endtask

   task automatic run_sample(input int code, input int g, input string req);
      longint e;
      e = f_exp(code, g);
      drive(code, g, 1'b0, 1'b0);
      @(negedge clk);
      chk(out_valid == 1'b0, {req, " R9 no early output"}, out_valid, 0);
      @(negedge clk);
      chk(out_valid == 1'b1, {req, " R9 valid after one edge"}, out_valid, 1);
      chk(out_code == 13'(e), req, out_code, e);
   endtask

   task automatic do_cal(input int h0, input int h1, input int m0, input int m1,
                         input int l0, input int l1, input bit bad);
      int cyc = 0;
      drive(h0, 0, 1'b1, 1'b0); drive(m0, 1, 1'b1, 1'b0);
      drive(l0, 2, 1'b1, 1'b0); drive(h1, 0, 1'b1, 1'b1);
      drive(m1, 1, 1'b1, 1'b1); drive(l1, 2, 1'b1, 1'b1);
      @(negedge clk);
      chk(busy == 1'b1, "R3 busy after sixth point", busy, 1);
      chk(out_valid == 1'b0, "R3 calibration makes no output", out_valid, 0);
      while (busy && cyc < 200) begin
         if (in_ready) chk(1'b0, "R8 in_ready low while busy", in_ready, 0);
         cyc++;
         @(negedge clk);
      end
      if (bad) begin
         chk(cyc == 1, "R7 busy one cycle on reject", cyc, 1);
         chk(cal_err == 1'b1, "R7 cal_err raised", cal_err, 1);
         r_md = 4096; r_lo = 4096; o_md = 0; o_lo = 0;
      end else begin
         chk(cyc <= 64, "R8 busy bounded", cyc, 64);
         chk(cal_err == 1'b0, "R10 cal_err clear after good calibration", cal_err, 0);
         r_md = f_ratio(h0, h1, m0, m1);
         r_lo = f_ratio(h0, h1, l0, l1);
         o_md = ((r_md * m1 + 2048) >>> 12) - h1;
         o_lo = ((r_lo * l1 + 2048) >>> 12) - h1;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);
      chk(busy == 1'b0, "R1 busy reset", busy, 0);
      chk(cal_err == 1'b0, "R1 cal_err reset", cal_err, 0);
      run_sample(1234, 1, "R1 unity medium");
      run_sample(4321, 2, "R1 unity low");
   endtask

   task automatic t_passthrough;
      run_sample(7777, 0, "R2 high passthrough");
      run_sample(55, 3, "R2 reserved tag passthrough");
   endtask

   task automatic t_ideal;
      do_cal(1000, 5000, 500, 2500, 250, 1250, 1'b0);
      chk(r_md == 8192, "R4 ideal medium ratio model", r_md, 8192);
      run_sample(2000, 1, "R6 ideal medium");
      run_sample(1000, 2, "R6 ideal low");
      run_sample(3000, 0, "R2 high after cal");
   endtask

   task automatic t_nonideal;
      do_cal(1000, 5000, 510, 2490, 240, 1270, 1'b0);
      run_sample(1777, 1, "R5 nonideal medium offset");
      run_sample(901, 2, "R5 nonideal low offset");
      run_sample(8000, 1, "R6 clamp high");
      run_sample(0, 1, "R6 clamp low");
   endtask

   task automatic t_saturate;
      do_cal(0, 4000, 100, 101, 200, 1200, 1'b0);
      chk(r_md == 65535, "R4 ratio saturates model", r_md, 65535);
      run_sample(100, 1, "R4 saturated ratio sample");
   endtask

   task automatic t_reject;
      do_cal(1000, 5000, 700, 700, 250, 1250, 1'b1);
      run_sample(2222, 1, "R7 unity after reject medium");
      run_sample(3333, 2, "R7 unity after reject low");
      do_cal(1000, 5000, 500, 2500, 250, 1250, 1'b0);
   endtask

   task automatic t_stall;
      longint e;
      e = f_exp(4000, 1);
      drive(4000, 1, 1'b0, 1'b0);
      out_ready = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(out_valid == 1'b1 && out_code == 13'(e), "R9 stalled output present", out_code, e);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b1 && out_code == 13'(e), "R9 stalled output holds", out_code, e);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 output drains", out_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_passthrough();
      t_ideal();
      t_nonideal();
      t_saturate();
      t_reject();
      t_stall();
      repeat (3) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule